// File: doc/BRIEF.md
# Self-Reloading DMA Channel with Bus Arbiter

This block is one memory-to-memory DMA channel that shares a single-port memory with a processor. A channel task is described by a six-word descriptor held in memory. A software pulse or an external trigger, arriving while the channel is idle, makes it read the descriptor found at `start_link`. The channel then moves 32-bit words one at a time. After every access it adds a signed step to the source or destination address, and it counts the remaining words down to zero. When a block finishes, the channel can raise a one-cycle interrupt. It can also follow the link held in the descriptor's first word and fetch the next task on its own, with no processor involvement.

The same descriptor can instead place the channel in split mode. In split mode one half streams memory words out to a link port's transmit side, and the other half writes words taken from the port's receive side into memory. The two halves advance independently of each other. The channel and the processor reach the memory through an arbiter inside the block. The arbiter can favour the processor, favour the channel, or alternate between them. Memory reads return data one cycle after the granted access.

Top module: `dma_link_chan`

## Requirements
- R1: While reset is active, and in the first cycle after it, `busy`, `bus_en`, `done_irq`, `tx_valid` and `rx_ready` are all low.
- R2: A pulse on `start_sw` or on `ext_trig` while idle makes the channel read six descriptor words from consecutive addresses, starting at `start_link`. Word 0 is the link word, then come source, source step, count, destination and destination step. In the link word, bits 31..3 hold the next descriptor address (its low three bits are zero), bit 0 enables chaining, bit 1 enables the interrupt and bit 2 selects split mode.
- R3: In normal mode each word is read from the source address and then written to the destination address. After each access the address just used is advanced by its signed step (0xFFFFFFFF means -1).
- R4: The count sets how many words are moved and is decremented after each one. A count of zero moves no data and makes no data access.
- R5: At the end of a block, `done_irq` is high for exactly one cycle if link-word bit 1 is set, and stays low otherwise.
- R6: At the end of a block with bit 0 set, the channel fetches the descriptor at the next address without any trigger. With bit 0 clear it returns to idle (`busy` low).
- R7: In split mode the transmit half moves `count` memory words to `tx_data`. It holds `tx_valid` and the data steady until `tx_ready` is high. The receive half writes `count` words from `rx_data` to the destination, popping each with a one-cycle `rx_ready`. A receive write has priority over a transmit read.
- R8: With `pri_mode` = 0, a processor request is always granted, and the channel waits.
- R9: With `pri_mode` = 1, a channel request always wins, and the processor gets only the cycles the channel leaves free.
- R10: With `pri_mode` = 2, when both sides request, the channel wins if the processor was granted in the previous cycle. Otherwise the processor wins.
- R11: At most one side is granted per cycle. A processor grant puts `cpu_addr`, `cpu_we` and `cpu_wdata` on the bus.
- R12: Triggers that arrive while the channel is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_mode | input | 2 | 0 processor first, 1 channel first, 2 alternating |
| start_sw | input | 1 | Software start pulse |
| ext_trig | input | 1 | External start pulse |
| start_link | input | 32 | Address of first descriptor |
| busy | output | 1 | Channel not idle |
| done_irq | output | 1 | Block-complete interrupt pulse |
| cpu_req | input | 1 | Processor memory request |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | 32 | Processor address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_gnt | output | 1 | Processor granted this cycle |
| bus_en | output | 1 | Memory access this cycle |
| bus_we | output | 1 | Memory write |
| bus_addr | output | 32 | Memory address |
| bus_wdata | output | 32 | Memory write data |
| bus_rdata | input | 32 | Memory read data, one cycle after the access |
| rx_valid | input | 1 | Receive word available |
| rx_data | input | 32 | Receive word |
| rx_ready | output | 1 | Receive word taken |
| tx_valid | output | 1 | Transmit word offered |
| tx_data | output | 32 | Transmit word |
| tx_ready | input | 1 | Transmit word accepted |

## Verification
A processor access and a channel access can both want the memory in the same cycle. The bench causes this by holding `cpu_req` high through a whole copy under each of the three priority modes. It judges the outcome from the grant pattern seen at the ports: no channel traffic under processor priority, no two back-to-back processor grants while busy under channel priority, and a channel grant only right after a processor grant in alternating mode. The written memory and the exact number of channel bus cycles are checked as well. In split mode a receive write and a transmit read can also contend, and the scoreboards of the two halves confirm that neither half loses or reorders a word.

// File: rtl/dma_link_chan.sv
module dma_link_chan #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pri_mode,
  input  logic          start_sw,
  input  logic          ext_trig,
  input  logic [AW-1:0] start_link,
  output logic          busy,
  output logic          done_irq,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_gnt,
  output logic          bus_en,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready
);
  localparam int NDESC = 6;
  localparam int DIW = $clog2(NDESC);

  typedef enum logic [1:0] {S_IDLE, S_DESC, S_RUN} st_t;
  typedef enum logic [1:0] {PH_RD, PH_CAP, PH_OUT} ph_t;

  st_t st;
  ph_t ph;
  logic [DIW-1:0] dix;
  logic dcap, f_chain, f_irq, f_split, last_cpu;
  logic [AW-1:0] link, nxt, src, dst, sinc, dinc;
  logic [DW-1:0] cnt, rxcnt, hold;

  logic desc_rq, rd_rq, wr_rq, rx_rq, dma_req, dma_gnt, blk_end;

  assign desc_rq = (st == S_DESC) && !dcap;
  assign rd_rq   = (st == S_RUN) && (ph == PH_RD) && (cnt != '0);
  assign wr_rq   = (st == S_RUN) && !f_split && (ph == PH_OUT);
  assign rx_rq   = (st == S_RUN) && f_split && rx_valid && (rxcnt != '0);
  assign dma_req = desc_rq | rd_rq | wr_rq | rx_rq;

  always_comb begin
    case (pri_mode)
      2'd0:    cpu_gnt = cpu_req;
      2'd1:    cpu_gnt = cpu_req && !dma_req;
      default: cpu_gnt = cpu_req && !(dma_req && last_cpu);
    endcase
  end
  assign dma_gnt = dma_req && !cpu_gnt;

  assign bus_en    = cpu_gnt | dma_gnt;
  assign bus_we    = cpu_gnt ? cpu_we : (dma_gnt && (wr_rq || rx_rq));
  assign bus_addr  = cpu_gnt ? cpu_addr :
                     desc_rq ? link + AW'(dix) :
                     (rx_rq || wr_rq) ? dst : src;
  assign bus_wdata = cpu_gnt ? cpu_wdata : (rx_rq ? rx_data : hold);

  assign rx_ready = dma_gnt && rx_rq;
  assign tx_valid = (st == S_RUN) && f_split && (ph == PH_OUT);
  assign tx_data  = hold;
  assign blk_end  = (st == S_RUN) && (ph == PH_RD) && (cnt == '0) && (rxcnt == '0);
  assign busy     = (st != S_IDLE);
  assign done_irq = blk_end && f_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_RD; dix <= '0; dcap <= 1'b0; last_cpu <= 1'b0;
      f_chain <= 1'b0; f_irq <= 1'b0; f_split <= 1'b0;
      link <= '0; nxt <= '0; src <= '0; dst <= '0; sinc <= '0; dinc <= '0;
      cnt <= '0; rxcnt <= '0; hold <= '0;
    end else begin
      last_cpu <= cpu_gnt;
      case (st)
        S_IDLE: if (start_sw || ext_trig) begin
          link <= start_link; dix <= '0; dcap <= 1'b0; st <= S_DESC;
        end
        S_DESC: begin
          if (desc_rq && dma_gnt) dcap <= 1'b1;
          if (dcap) begin
            dcap <= 1'b0;
            dix  <= dix + 1'b1;
            case (dix)
              DIW'(0): begin
                nxt <= {bus_rdata[AW-1:3], 3'b000};
                f_chain <= bus_rdata[0]; f_irq <= bus_rdata[1]; f_split <= bus_rdata[2];
              end
              DIW'(1): src  <= bus_rdata;
              DIW'(2): sinc <= bus_rdata;
              DIW'(3): begin cnt <= bus_rdata; rxcnt <= f_split ? bus_rdata : '0; end
              DIW'(4): dst  <= bus_rdata;
              default: begin dinc <= bus_rdata; st <= S_RUN; ph <= PH_RD; end
            endcase
          end
        end
        S_RUN: begin
          if (dma_gnt && rd_rq && !rx_rq) begin src <= src + sinc; ph <= PH_CAP; end
          if (ph == PH_CAP) begin hold <= bus_rdata; ph <= PH_OUT; end
          if (dma_gnt && wr_rq) begin dst <= dst + dinc; cnt <= cnt - 1'b1; ph <= PH_RD; end
          if (tx_valid && tx_ready) begin cnt <= cnt - 1'b1; ph <= PH_RD; end
          if (dma_gnt && rx_rq) begin dst <= dst + dinc; rxcnt <= rxcnt - 1'b1; end
          if (blk_end) begin
            if (f_chain) begin link <= nxt; dix <= '0; st <= S_DESC; end
            else st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_link_chan_chk.sv
module dma_link_chan_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    pri_mode,
  input logic          cpu_req,
  input logic          cpu_gnt,
  input logic          dma_req,
  input logic          dma_gnt,
  input logic          done_irq,
  input logic          busy,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data
);
  a_r11_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_gnt, dma_gnt}));
  a_r8_cpu_first: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_mode == 2'd0 && cpu_req) |-> cpu_gnt);
  a_r9_dma_first: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_mode == 2'd1 && dma_req) |-> dma_gnt);
  a_r10_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_mode == 2'd2 && cpu_req && dma_req && $past(cpu_gnt && rst_n)) |-> dma_gnt);
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  a_r7_rx_pop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_valid);
  a_r5_irq_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> busy);
endmodule

bind dma_link_chan dma_link_chan_chk #(.DW(DW)) chk_i (.*);

// File: tb/dma_link_chan_tb_top.sv
`timescale 1ns/1ps
module dma_link_chan_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start_sw, ext_trig, busy, done_irq, cpu_req, cpu_we, cpu_gnt;
  logic bus_en, bus_we, rx_valid, rx_ready, tx_valid, tx_ready;
  logic [1:0] pri_mode;
  logic [31:0] start_link, cpu_addr, cpu_wdata, bus_addr, bus_wdata, rx_data, tx_data;
  logic [31:0] rdq;

  dma_link_chan dut_i (
    .clk(clk), .rst_n(rst_n), .pri_mode(pri_mode), .start_sw(start_sw), .ext_trig(ext_trig),
    .start_link(start_link), .busy(busy), .done_irq(done_irq), .cpu_req(cpu_req),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_gnt(cpu_gnt),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdq), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready));

  logic [31:0] mem [0:1023];
  always @(posedge clk)
    if (bus_en) begin
      if (bus_we) mem[bus_addr[9:0]] <= bus_wdata;
      else rdq <= mem[bus_addr[9:0]];
    end

  logic [31:0] rxarr [0:7];
  int rx_ptr = 0;
  int rx_n = 0;
  assign rx_valid = rx_ptr < rx_n;
  assign rx_data = rxarr[rx_ptr[2:0]];
  always @(posedge clk) if (rx_ready) rx_ptr <= rx_ptr + 1;
  logic tx_tog = 1'b0, tx_en = 1'b0;
  always @(posedge clk) tx_tog <= ~tx_tog;
  assign tx_ready = tx_tog & tx_en;

  typedef struct { logic [31:0] a; logic [31:0] d; } item_t;
  item_t wq[$];
  logic [31:0] txq[$];
  int nchk = 0, nerr = 0;
  int irq_n = 0, dma_n = 0, cc2 = 0, dmabad = 0, cpu_busy_n = 0;
  logic prev_cg = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (bus_en && bus_we && !cpu_gnt) begin
      if (wq.size() == 0) chk(0, "R3", "unexpected dma write addr", bus_addr, 32'h0);
      else begin
        item_t it;
        it = wq.pop_front();
        chk(bus_addr == it.a, "R3", "write addr", bus_addr, it.a);
        chk(bus_wdata == it.d, "R3", "write data", bus_wdata, it.d);
      end
    end
    if (tx_valid && tx_ready) begin
      if (txq.size() == 0) chk(0, "R7", "unexpected tx word", tx_data, 32'h0);
      else begin
        logic [31:0] e;
        e = txq.pop_front();
        chk(tx_data == e, "R7", "tx word", tx_data, e);
      end
    end
    if (cpu_gnt) chk(bus_addr == cpu_addr && bus_we == cpu_we, "R11", "cpu bus mux", bus_addr, cpu_addr);
    if (done_irq) irq_n++;
    if (bus_en && !cpu_gnt) dma_n++;
    if (busy && cpu_gnt && prev_cg) cc2++;
    if (busy && cpu_gnt) cpu_busy_n++;
    if (bus_en && !cpu_gnt && cpu_req && !prev_cg) dmabad++;
    prev_cg = cpu_gnt;
  end

  task automatic setdesc(input int b, input logic [31:0] w0, s, si, c, d, di);
    mem[b] = w0; mem[b+1] = s; mem[b+2] = si; mem[b+3] = c; mem[b+4] = d; mem[b+5] = di;
  endtask

  task automatic go_sw(input logic [31:0] l);
    @(negedge clk); start_link = l; start_sw = 1'b1;
    @(negedge clk); start_sw = 1'b0;
  endtask

  task automatic wait_idle(input int maxc, input string req);
    int n = 0;
    repeat (2) @(negedge clk);
    while (busy && n < maxc) begin @(negedge clk); n++; end
    chk(!busy, req, "channel returns idle", {31'b0, busy}, 32'h0);
  endtask

  task automatic push_copy4();
    for (int i = 0; i < 4; i++) begin
      item_t it;
      it.a = 32'h200 + i; it.d = 32'hA500_0000 + i;
      wq.push_back(it);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WD", "watchdog expired", 32'h0, 32'h0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_sw = 1'b0; ext_trig = 1'b0; start_link = '0; pri_mode = 2'd0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = 32'h3FF; cpu_wdata = '0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < 4; i++) mem[32'h100 + i] = 32'hA500_0000 + i;
    repeat (3) @(negedge clk);
    chk(!busy && !bus_en && !done_irq && !tx_valid && !rx_ready, "R1", "outputs in reset",
        {27'b0, busy, bus_en, done_irq, tx_valid, rx_ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_en && !done_irq && !tx_valid && !rx_ready, "R1", "outputs after reset",
        {27'b0, busy, bus_en, done_irq, tx_valid, rx_ready}, 32'h0);

    // R2 R3 R5 R12: plain copy, irq on, extra trigger while busy
    setdesc(32'h40, 32'h2, 32'h100, 32'h1, 32'd4, 32'h200, 32'h1);
    setdesc(32'h60, 32'h2, 32'h100, 32'h1, 32'd1, 32'h3F0, 32'h1);
    push_copy4();
    irq_n = 0;
    go_sw(32'h40);
    repeat (5) @(negedge clk);
    start_link = 32'h60; start_sw = 1'b1; @(negedge clk); start_sw = 1'b0;
    wait_idle(500, "R6");
    repeat (30) @(negedge clk);
    chk(!busy, "R12", "trigger while busy ignored", {31'b0, busy}, 32'h0);
    chk(wq.size() == 0, "R3", "all copy words written", wq.size(), 32'h0);
    chk(irq_n == 1, "R5", "one irq pulse", irq_n, 32'd1);

    // R2 R4 R6: external trigger, negative step, chain to zero-count block
    mem[32'h10D] = 32'h1111_0001; mem[32'h10E] = 32'h2222_0002; mem[32'h10F] = 32'h3333_0003;
    setdesc(32'h80, 32'h48 | 32'h1, 32'h10F, 32'hFFFF_FFFF, 32'd3, 32'h300, 32'h2);
    setdesc(32'h48, 32'h2, 32'h0, 32'h0, 32'd0, 32'h0, 32'h0);
    begin
      item_t it;
      it.a = 32'h300; it.d = 32'h3333_0003; wq.push_back(it);
      it.a = 32'h302; it.d = 32'h2222_0002; wq.push_back(it);
      it.a = 32'h304; it.d = 32'h1111_0001; wq.push_back(it);
    end
    irq_n = 0; dma_n = 0;
    @(negedge clk); start_link = 32'h80; ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
    wait_idle(500, "R6");
    chk(wq.size() == 0, "R3", "negative-step copy complete", wq.size(), 32'h0);
    chk(irq_n == 1, "R5", "irq only from second block", irq_n, 32'd1);
    chk(dma_n == 18, "R4", "bus cycles, zero count moves nothing", dma_n, 32'd18);
    chk(mem[32'h301] == 32'h0, "R3", "step skips odd word", mem[32'h301], 32'h0);

    // R7: split mode
    for (int i = 0; i < 3; i++) begin
      item_t it;
      rxarr[i] = 32'hC0DE_0000 + i;
      it.a = 32'h280 + i; it.d = 32'hC0DE_0000 + i; wq.push_back(it);
      mem[32'h180 + i] = 32'h7E00_0000 + i;
      txq.push_back(32'h7E00_0000 + i);
    end
    setdesc(32'h50, 32'h6, 32'h180, 32'h1, 32'd3, 32'h280, 32'h1);
    rx_n = 3; tx_en = 1'b1; irq_n = 0;
    go_sw(32'h50);
    wait_idle(500, "R7");
    chk(wq.size() == 0, "R7", "rx half wrote all words", wq.size(), 32'h0);
    chk(txq.size() == 0, "R7", "tx half sent all words", txq.size(), 32'h0);
    chk(rx_ptr == 3, "R7", "rx words popped", rx_ptr, 32'd3);
    chk(irq_n == 1, "R5", "split block irq", irq_n, 32'd1);
    tx_en = 1'b0;

    // R8: processor priority starves the channel
    pri_mode = 2'd0; cpu_req = 1'b1; push_copy4(); dma_n = 0;
    go_sw(32'h40);
    repeat (40) @(negedge clk);
    chk(dma_n == 0, "R8", "no channel access under cpu priority", dma_n, 32'h0);
    chk(busy, "R8", "channel still pending", {31'b0, busy}, 32'h1);
    cpu_req = 1'b0;
    wait_idle(500, "R8");
    chk(dma_n == 14, "R8", "channel bus cycles after release", dma_n, 32'd14);

    // R9: channel priority
    pri_mode = 2'd1; cpu_req = 1'b1; push_copy4(); dma_n = 0; cc2 = 0; cpu_busy_n = 0;
    go_sw(32'h40);
    wait_idle(500, "R9");
    chk(cc2 == 0, "R9", "no back-to-back cpu grants while busy", cc2, 32'h0);
    chk(cpu_busy_n > 0, "R9", "cpu served in idle slots", cpu_busy_n, 32'h1);
    chk(dma_n == 14, "R9", "channel bus cycles", dma_n, 32'd14);

    // R10: alternating
    pri_mode = 2'd2; push_copy4(); dma_n = 0; dmabad = 0;
    go_sw(32'h40);
    wait_idle(500, "R10");
    chk(dmabad == 0, "R10", "channel grant only after cpu grant", dmabad, 32'h0);
    chk(dma_n == 14, "R10", "channel progresses", dma_n, 32'd14);
    chk(wq.size() == 0, "R10", "copies done under contention", wq.size(), 32'h0);
    cpu_req = 1'b0;
    repeat (5) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule